// File: doc/BRIEF.md
# Remote I/O Port Register Core

This block holds the register set behind one 8-bit port of a remote I/O expander. A host reaches it through a simple synchronous register bus. Per pin, the host chooses the direction, the driven value, whether the output is push-pull or open-drain, and a read-side polarity flip. The pins are sampled through a two-stage synchronizer. The value the host last read is kept as a snapshot of the port.

An active-low interrupt line goes low while any unmasked input pin differs from that snapshot. The interrupt status register shows which bits are responsible. Reading the input register takes a new snapshot, which clears the condition. An input bit can also be set to latch: its first change is then held, with the interrupt, until the host reads the port, even if the pin goes back to its old level.

Every register can be read back. A hardware reset puts all registers at their defaults, with every pin an input. So does a software reset, which is a key value written to a command address. The pull resistor settings are stored and read back here but have no effect in this block.

Top module: `gpio_port_core`

## Requirements
- R1: After reset, the registers read back as follows: address 1 (output data) 0xFF, 2 (polarity) 0x00, 3 (direction, 1 = input) 0xFF, 4 (latch enable) 0x00, 5 (pull enable) 0x00, 6 (pull select) 0x00, 7 (interrupt mask, 1 = masked) 0xFF, 8 (interrupt status) 0x00, 9 (output mode, 1 = open-drain) 0x00. After reset, pin_oe is 0x00 and irq_n is 1.
- R2: Addresses 1 to 7 and 9 read back the last value written. Writes to address 0 (input) and address 8 (status) have no effect. bus_rdata is 0 when bus_re is low.
- R3: A pin with direction 0 and output mode 0 has pin_oe set and pin_out equal to its output data bit.
- R4: A pin with output mode 1 always has pin_out 0. If it is an output, pin_oe is the inverse of its output data bit, so a 1 releases the pin.
- R5: Reading address 0 returns, for each bit, the pin value delayed by two clock edges XOR the polarity bit.
- R6: A non-latched input bit whose synchronized pin value differs from its snapshot sets its status bit and drives irq_n low, combinationally from the synchronized value. This lasts only while the difference exists.
- R7: A read of address 0 loads the snapshot with the synchronized pins and clears every held latch. From the next cycle, status is 0 for any bit whose pin has not changed since.
- R8: A bit with mask 1 never sets its status bit and never pulls irq_n low.
- R9: A latched input bit (latch enable 1) takes its first change into the snapshot one edge after it reaches the synchronizer and holds it, with its status bit, until address 0 is read. Reads of address 0 return the held value, even if the pin has already returned.
- R10: A pin configured as an output never sets its status bit.
- R11: Writing 0xA5 to address 10 restores every register, the snapshot and the latches to their reset values. Any other value written there has no effect.
- R12: A pin change that reaches the synchronizer output in the cycle after a read of address 0 still raises the interrupt. A change that reaches it before the read is returned by that read and cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_re |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Value driven on each pin |
| pin_oe | output | 8 | Output enable per pin |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two events can fall on the same clock edge: the host reads the input register, and a pin change arrives at the synchronizer output. The bench provokes this by driving a pin change and the read strobe in one cycle, and again with the change advanced so that it lands just before the read. In the first case the interrupt must come back after the read. In the second, the read data must already carry the new level and the interrupt must clear. A behavioural reference model, which keeps the pin history as a short delay line, judges irq_n, pin_oe, pin_out and every read on every cycle.

// File: rtl/gpio_pkg.sv
// gpio_pkg: shared address map and constants for the port register core.
// Assumes a 4-bit register address; data width is set by each module.
package gpio_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_IN       = 4'd0,
        REG_OUT      = 4'd1,
        REG_POL      = 4'd2,
        REG_DIR      = 4'd3,
        REG_LATCH    = 4'd4,
        REG_PULL_EN  = 4'd5,
        REG_PULL_SEL = 4'd6,
        REG_MASK     = 4'd7,
        REG_STAT     = 4'd8,
        REG_ODMODE   = 4'd9,
        REG_SRST     = 4'd10
    } reg_addr_e;

    localparam logic [7:0] SRST_KEY = 8'hA5;
endpackage

// File: rtl/gpio_sync.sv
// gpio_sync: multi-stage synchronizer for asynchronous pin levels.
// Assumes each pin is sampled independently; no bus coherence is implied.
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the pin levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
// gpio_cfg_regs: host-writable configuration registers and software reset decode.
// Assumes one write per cycle; the software reset key takes priority over the write.
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic              soft_rst,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      pol_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      lat_q,
    output logic [W-1:0]      pen_q,
    output logic [W-1:0]      psel_q,
    output logic [W-1:0]      mask_q,
    output logic [W-1:0]      od_q
);
    // Decode the software reset command.
    assign soft_rst = wr_en && (wr_addr == REG_SRST) && (wr_data == W'(SRST_KEY));

    // Hold configuration; both reset sources restore defaults.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            out_q  <= '1;
            pol_q  <= '0;
            dir_q  <= '1;
            lat_q  <= '0;
            pen_q  <= '0;
            psel_q <= '0;
            mask_q <= '1;
            od_q   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_OUT:      out_q  <= wr_data;
                REG_POL:      pol_q  <= wr_data;
                REG_DIR:      dir_q  <= wr_data;
                REG_LATCH:    lat_q  <= wr_data;
                REG_PULL_EN:  pen_q  <= wr_data;
                REG_PULL_SEL: psel_q <= wr_data;
                REG_MASK:     mask_q <= wr_data;
                REG_ODMODE:   od_q   <= wr_data;
                default:      ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_in_track.sv
// gpio_in_track: per-bit input snapshot, change latching and interrupt cause.
// Assumes pin_s is already synchronized; rd_in marks a host read of the input register.
module gpio_in_track #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         rd_in,
    input  logic [W-1:0] pin_s,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] lat_q,
    input  logic [W-1:0] mask_q,
    output logic [W-1:0] in_raw,
    output logic [W-1:0] held_q,
    output logic [W-1:0] stat
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic snap_b;
        logic held_b;
        logic cause_b;

        // Track the snapshot and the held change for one bit.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                snap_b <= 1'b0;
                held_b <= 1'b0;
            end else if (rd_in) begin
                snap_b <= pin_s[i];
                held_b <= 1'b0;
            end else if (!lat_q[i]) begin
                held_b <= 1'b0;
            end else if (!held_b && (pin_s[i] != snap_b)) begin
                snap_b <= pin_s[i];
                held_b <= 1'b1;
            end
        end

        // Cause: held change when latching, live mismatch otherwise.
        assign cause_b   = lat_q[i] ? held_b : (pin_s[i] != snap_b);
        assign stat[i]   = dir_q[i] & ~mask_q[i] & cause_b;
        assign in_raw[i] = (lat_q[i] && held_b) ? snap_b : pin_s[i];
        assign held_q[i] = held_b;
    end
endmodule

// File: rtl/gpio_pin_drive.sv
// gpio_pin_drive: per-pin output value and enable for push-pull or open-drain use.
// Assumes dir bit 1 means input; open-drain pins never drive a high level.
module gpio_pin_drive #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] od_q,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        // Select drive behaviour for one pin.
        always_comb begin
            if (od_q[i]) begin
                pin_out[i] = 1'b0;
                pin_oe[i]  = ~dir_q[i] & ~out_q[i];
            end else begin
                pin_out[i] = out_q[i];
                pin_oe[i]  = ~dir_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_port_core.sv
// gpio_port_core: register core of one I/O expander port.
// Assumes a synchronous bus with single-cycle strobes; read data is combinational.
module gpio_port_core
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq_n
);
    logic             soft_rst;
    logic             rd_in;
    logic [WIDTH-1:0] pin_s;
    logic [WIDTH-1:0] out_q, pol_q, dir_q, lat_q, pen_q, psel_q, mask_q, od_q;
    logic [WIDTH-1:0] in_raw, held_q, stat;

    assign rd_in = bus_re && (bus_addr == REG_IN);

    gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_s)
    );

    gpio_cfg_regs #(.W(WIDTH)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .soft_rst (soft_rst),
        .out_q    (out_q),
        .pol_q    (pol_q),
        .dir_q    (dir_q),
        .lat_q    (lat_q),
        .pen_q    (pen_q),
        .psel_q   (psel_q),
        .mask_q   (mask_q),
        .od_q     (od_q)
    );

    gpio_in_track #(.W(WIDTH)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .rd_in    (rd_in),
        .pin_s    (pin_s),
        .dir_q    (dir_q),
        .lat_q    (lat_q),
        .mask_q   (mask_q),
        .in_raw   (in_raw),
        .held_q   (held_q),
        .stat     (stat)
    );

    gpio_pin_drive #(.W(WIDTH)) u_drive (
        .dir_q   (dir_q),
        .out_q   (out_q),
        .od_q    (od_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // Read multiplexer; returns zero outside a read strobe.
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (bus_addr)
                REG_IN:       bus_rdata = in_raw ^ pol_q;
                REG_OUT:      bus_rdata = out_q;
                REG_POL:      bus_rdata = pol_q;
                REG_DIR:      bus_rdata = dir_q;
                REG_LATCH:    bus_rdata = lat_q;
                REG_PULL_EN:  bus_rdata = pen_q;
                REG_PULL_SEL: bus_rdata = psel_q;
                REG_MASK:     bus_rdata = mask_q;
                REG_STAT:     bus_rdata = stat;
                REG_ODMODE:   bus_rdata = od_q;
                default:      bus_rdata = '0;
            endcase
        end
    end

    assign irq_n = ~|stat;
endmodule

// File: rtl/gpio_port_core_chk.sv
// gpio_port_core_chk: temporal checks on the port core, attached by bind.
// Assumes the default address map from gpio_pkg.
module gpio_port_core_chk
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              bus_re,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              soft_rst,
    input logic              irq_n,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      od_q,
    input logic [W-1:0]      out_q,
    input logic [W-1:0]      mask_q,
    input logic [W-1:0]      held_q,
    input logic [W-1:0]      stat
);
    logic in_rd, lat_wr;
    assign in_rd  = bus_re && (bus_addr == REG_IN);
    assign lat_wr = bus_we && (bus_addr == REG_LATCH);

    assert_pushpull_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q & ~od_q & ~pin_oe) == '0));

    assert_od_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & od_q & out_q) == '0));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rd && !soft_rst) |=> (held_q == '0));

    assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & mask_q) == '0));

    assert_latch_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_rd && !soft_rst && !lat_wr) |=> ((held_q & $past(held_q)) == $past(held_q)));

    assert_outputs_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~dir_q) == '0));

    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (pin_oe == '0 && irq_n));
endmodule

bind gpio_port_core gpio_port_core_chk #(.W(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_addr (bus_addr),
    .soft_rst (soft_rst),
    .irq_n    (irq_n),
    .pin_oe   (pin_oe),
    .dir_q    (dir_q),
    .od_q     (od_q),
    .out_q    (out_q),
    .mask_q   (mask_q),
    .held_q   (held_q),
    .stat     (stat)
);

// File: tb/gpio_port_core_tb.sv
`timescale 1ns/1ps
module gpio_port_core_tb;
    import gpio_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq_n;

    always #4 clk = ~clk;

    gpio_port_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_n     (irq_n)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] hist [$];   // pin history, newest at the back
    logic [7:0] m_snap, m_held, m_out, m_pol, m_dir, m_lat, m_pen, m_psel, m_mask, m_od;

    task automatic m_defaults();
        m_out = 8'hFF; m_pol = 8'h00; m_dir = 8'hFF; m_lat = 8'h00;
        m_pen = 8'h00; m_psel = 8'h00; m_mask = 8'hFF; m_od = 8'h00;
        m_snap = 8'h00; m_held = 8'h00;
    endtask

    function automatic logic [7:0] m_pins();
        return hist[0];
    endfunction

    function automatic logic [7:0] m_stat();
        logic [7:0] s = '0;
        for (int i = 0; i < 8; i++) begin
            logic c;
            c = m_lat[i] ? m_held[i] : (m_pins() >> i & 1) != (m_snap >> i & 1);
            s[i] = m_dir[i] && !m_mask[i] && c;
        end
        return s;
    endfunction

    function automatic logic [7:0] m_read(input logic [3:0] a);
        logic [7:0] v = '0;
        case (a)
            4'd0: for (int i = 0; i < 8; i++)
                      v[i] = ((m_lat[i] && m_held[i]) ? m_snap[i] : m_pins()[i]) ^ m_pol[i];
            4'd1: v = m_out;  4'd2: v = m_pol;  4'd3: v = m_dir;
            4'd4: v = m_lat;  4'd5: v = m_pen;  4'd6: v = m_psel;
            4'd7: v = m_mask; 4'd8: v = m_stat(); 4'd9: v = m_od;
            default: v = '0;
        endcase
        return v;
    endfunction

    initial begin
        m_defaults();
        hist = '{8'h00, 8'h00};
    end

    // Advance the model on every rising edge from the inputs that were set up for it.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_defaults();
            hist = '{8'h00, 8'h00};
        end else begin
            if (bus_we && bus_addr == 4'd10 && bus_wdata == 8'hA5) begin
                m_defaults();
            end else begin
                for (int i = 0; i < 8; i++) begin
                    if (bus_re && bus_addr == 4'd0) begin
                        m_snap[i] = m_pins()[i];
                        m_held[i] = 1'b0;
                    end else if (!m_lat[i]) begin
                        m_held[i] = 1'b0;
                    end else if (!m_held[i] && m_pins()[i] != m_snap[i]) begin
                        m_snap[i] = m_pins()[i];
                        m_held[i] = 1'b1;
                    end
                end
                if (bus_we) begin
                    case (bus_addr)
                        4'd1: m_out = bus_wdata;  4'd2: m_pol = bus_wdata;
                        4'd3: m_dir = bus_wdata;  4'd4: m_lat = bus_wdata;
                        4'd5: m_pen = bus_wdata;  4'd6: m_psel = bus_wdata;
                        4'd7: m_mask = bus_wdata; 4'd9: m_od = bus_wdata;
                        default: ;
                    endcase
                end
            end
            void'(hist.pop_front());
            hist.push_back(pin_in);
        end
    end

    // Compare every cycle, away from both clock edges.
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic [7:0] e_oe, e_out;
            for (int i = 0; i < 8; i++) begin
                e_out[i] = m_od[i] ? 1'b0 : m_out[i];
                e_oe[i]  = !m_dir[i] && (!m_od[i] || !m_out[i]);
            end
            check("R6 model irq_n", {7'd0, irq_n}, {7'd0, (m_stat() == 8'h00)});
            check("R3 model pin_oe", pin_oe, e_oe);
            check("R4 model pin_out", pin_out, e_out);
            check("R2 model rdata", bus_rdata, bus_re ? m_read(bus_addr) : 8'h00);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_re = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk); bus_re = 1'b0;
    endtask

    task automatic pins_and_read(input logic [7:0] p, output logic [7:0] d);
        @(negedge clk); pin_in = p; bus_re = 1'b1; bus_addr = 4'd0;
        #2 d = bus_rdata;
        @(negedge clk); bus_re = 1'b0;
    endtask

    task automatic setpins(input logic [7:0] p);
        @(negedge clk); pin_in = p;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        rd(4'd1, d); check("R1 out", d, 8'hFF);
        rd(4'd2, d); check("R1 pol", d, 8'h00);
        rd(4'd3, d); check("R1 dir", d, 8'hFF);
        rd(4'd4, d); check("R1 latch", d, 8'h00);
        rd(4'd7, d); check("R1 mask", d, 8'hFF);
        rd(4'd8, d); check("R1 stat", d, 8'h00);
        rd(4'd9, d); check("R1 odmode", d, 8'h00);

        // R2 readback and ignored writes
        wr(4'd2, 8'h3C); rd(4'd2, d); check("R2 pol", d, 8'h3C);
        wr(4'd5, 8'h96); rd(4'd5, d); check("R2 pull_en", d, 8'h96);
        wr(4'd6, 8'h69); rd(4'd6, d); check("R2 pull_sel", d, 8'h69);
        wr(4'd0, 8'hFF); rd(4'd0, d); check("R2 input write ignored", d, 8'h3C);
        wr(4'd8, 8'hFF); rd(4'd8, d); check("R2 status write ignored", d, 8'h00);
        wr(4'd2, 8'h00);

        // R3 push-pull drive
        wr(4'd1, 8'h5A); wr(4'd3, 8'hF0);
        check("R3 pin_oe", pin_oe, 8'h0F);
        check("R3 pin_out", pin_out, 8'h5A);

        // R4 open-drain drive
        wr(4'd9, 8'h0F);
        check("R4 pin_oe", pin_oe, 8'h05);
        check("R4 pin_out", pin_out, 8'h50);
        wr(4'd3, 8'hFF); wr(4'd9, 8'h00); wr(4'd1, 8'hFF);

        // R5 synchronized input with polarity
        wr(4'd2, 8'h0F); setpins(8'h3C); idle(4);
        rd(4'd0, d); check("R5 input read", d, 8'h33);

        // R6 / R7 live mismatch interrupt and read clear
        wr(4'd7, 8'h00); idle(1);
        check("R6 no mismatch", {7'd0, irq_n}, 8'h01);
        setpins(8'h3D); idle(3);
        check("R6 irq asserted", {7'd0, irq_n}, 8'h00);
        rd(4'd8, d); check("R6 status bit0", d, 8'h01);
        setpins(8'h3C); idle(3);
        check("R6 irq follows pin back", {7'd0, irq_n}, 8'h01);
        setpins(8'h7C); idle(3);
        rd(4'd8, d); check("R6 status bit6", d, 8'h40);
        rd(4'd0, d); check("R7 read value", d, 8'h73);
        check("R7 irq cleared", {7'd0, irq_n}, 8'h01);
        rd(4'd8, d); check("R7 status cleared", d, 8'h00);

        // R8 mask
        wr(4'd7, 8'h80); setpins(8'hFC); idle(3);
        check("R8 masked irq", {7'd0, irq_n}, 8'h01);
        rd(4'd8, d); check("R8 masked status", d, 8'h00);
        rd(4'd0, d); wr(4'd7, 8'h00);

        // R10 output pins ignored
        wr(4'd3, 8'h7F); setpins(8'h7C); idle(3);
        check("R10 output pin irq", {7'd0, irq_n}, 8'h01);
        rd(4'd8, d); check("R10 output pin status", d, 8'h00);
        wr(4'd3, 8'hFF); rd(4'd0, d); idle(1);

        // R9 latched input survives a glitch
        wr(4'd4, 8'h02); rd(4'd0, d);
        setpins(8'h7E); idle(4); setpins(8'h7C); idle(4);
        check("R9 latched irq", {7'd0, irq_n}, 8'h00);
        rd(4'd8, d); check("R9 latched status", d, 8'h02);
        rd(4'd0, d); check("R9 held value read", d, 8'h71);
        check("R9 irq after read", {7'd0, irq_n}, 8'h01);
        rd(4'd0, d); check("R9 fresh value", d, 8'h73);

        // R12 read coinciding with a pin change
        pins_and_read(8'h78, d);
        check("R12 read before change", d, 8'h73);
        idle(3);
        check("R12 late change raises irq", {7'd0, irq_n}, 8'h00);
        rd(4'd8, d); check("R12 late change status", d, 8'h04);
        rd(4'd0, d); check("R12 reread", d, 8'h77);
        setpins(8'h7C); idle(1);
        rd(4'd0, d); check("R12 early change returned", d, 8'h73);
        check("R12 early change cleared", {7'd0, irq_n}, 8'h01);

        // R11 software reset
        wr(4'd3, 8'h00);
        wr(4'd10, 8'h5A);
        rd(4'd4, d); check("R11 wrong key latch kept", d, 8'h02);
        check("R11 wrong key oe kept", pin_oe, 8'hFF);
        wr(4'd10, 8'hA5);
        check("R11 oe default", pin_oe, 8'h00);
        check("R11 irq default", {7'd0, irq_n}, 8'h01);
        rd(4'd4, d); check("R11 latch default", d, 8'h00);
        rd(4'd7, d); check("R11 mask default", d, 8'hFF);
        rd(4'd2, d); check("R11 pol default", d, 8'h00);

        idle(2);
        finish_run();
    end
endmodule